// File: doc/BRIEF.md
# Serial Command Front End for a Twelve-Channel Trim DAC Controller

This block is the serial entry point of a trim DAC controller. A host sends framed 16-bit command words over a three-wire link: an active-low chip select, a serial clock and a data line. The serial clock and chip select are much slower than the controller's system clock. They are brought into the system domain through synchronisers, and the block works on their edges there. When a frame closes, the block decodes the captured word. It then raises a single one-cycle strobe for the rest of the controller: a DAC latch load, a single-channel recall, a recall of all channels, a storage write or a storage read. The strobe comes with the channel index, the bank and the data byte.

The level of the serial clock when chip select falls decides what the frame is. If the clock is high, the frame is a command and bits are shifted in. If the clock is low, the frame is a status query, and the serial output reports whether nonvolatile storage is busy. The serial output is driven as a data bit plus an enable. The enable is low whenever no frame is open. During a command frame the output carries the bits that fall out of the shift register, so several devices can be daisy-chained. A byte returned by storage after a read command is loaded into the shift register and leaves on the output during the next frame.

The read-return path `rd_valid_i`/`rd_data_i` is a valid-only stream with no back-pressure. A byte is taken in the cycle its valid is high. While a command frame is shifting, a returned byte is dropped, so the storage side should answer between frames. The command strobes have no ready signal, and their consumer must accept them in the cycle they appear.

Top module: `trim_cmd_serial_if`

## Requirements
- R1: After reset, every strobe is low and `sdo_oe_o` is low.
- R2: If chip select falls while the serial clock is high, a command frame opens. Bits are sampled on rising serial clock edges, LSB first. In the word, bits 7:0 are the data byte, bits 11:8 are the channel code, bit 12 is WR, bit 13 is CL and bits 15:14 are the bank.
- R3: A command executes on the rising edge of chip select, and only if at least 16 bits were shifted in that frame. A frame of 15 bits or fewer does nothing.
- R4: If more than 16 bits are shifted, the last 16 form the command. In a command frame, `sdo_o` is updated on each falling serial clock edge to the register's oldest bit, so an input bit reappears 16 clocks later.
- R5: {CL,WR}=00 with channel code 1..12 pulses `dac_ld_o`, with `cmd_chan_o` = code-1 and `cmd_data_o` = the data byte. Codes 0, 13, 14 and 15 do nothing.
- R6: {CL,WR}=10 with code 1..12 pulses `recall_o`. Code 0 pulses `recall_all_o`. `cmd_bank_o` carries the bank in both cases. Codes 13, 14 and 15 do nothing.
- R7: {CL,WR}=11 with code 0 enables storage writes, and with code 15 disables them. Writes are disabled after reset. {CL,WR}=01 with code 1..12 pulses `nv_wr_o` only while writes are enabled.
- R8: {CL,WR}=11 with code 1..12 pulses `nv_rd_o`. A byte presented with `rd_valid_i` leaves on `sdo_o` LSB first in the next command frame, followed by zeros.
- R9: If chip select falls while the serial clock is low, status mode opens. `sdo_oe_o` is high and `sdo_o` is low while `nv_busy_i` is high and high while it is low. Closing a status frame executes nothing.
- R10: Recall, recall-all, write and read are dropped when `nv_busy_i` is high at execution. DAC loads are not.
- R11: `sdo_oe_o` is low while chip select is high.
- R12: Each strobe lasts one system cycle, at most one strobe is high at a time, and it appears in the third system cycle after chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Chip select, active low, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out / ready flag |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |
| nv_busy_i | input | 1 | Nonvolatile storage busy |
| rd_valid_i | input | 1 | Read-return byte valid |
| rd_data_i | input | 8 | Read-return byte |
| dac_ld_o | output | 1 | DAC latch load strobe |
| recall_o | output | 1 | Single-channel recall strobe |
| recall_all_o | output | 1 | All-channel recall strobe |
| nv_wr_o | output | 1 | Storage write strobe |
| nv_rd_o | output | 1 | Storage read strobe |
| cmd_chan_o | output | 4 | Channel index 0..11 |
| cmd_bank_o | output | 2 | Storage bank |
| cmd_data_o | output | 8 | Command data byte |

## Verification
Every result that follows a serial pin change arrives three system cycles later: two synchroniser flops, then the register that acts on the detected edge. The bench drives all pins on falling system clock edges and checks strobes on exactly the third falling edge after chip select rises. It also watches a six-cycle window, so a pulse that is late, early or repeated is caught. Serial output bits are read after four system cycles of low serial clock, just before the next rising edge, which is well past their three-cycle latency. The status flag follows the busy input one cycle later and is read two cycles after busy changes.

// File: rtl/trimser_pkg.sv
package trimser_pkg;

  // Frame state selected by the serial clock level at chip-select fall
  typedef enum logic [1:0] {
    FR_IDLE   = 2'd0,
    FR_SHIFT  = 2'd1,
    FR_STATUS = 2'd2
  } frame_mode_e;

  // Opcode formed as {CL, WR}
  typedef enum logic [1:0] {
    OP_DAC    = 2'b00,
    OP_WRITE  = 2'b01,
    OP_RECALL = 2'b10,
    OP_READ   = 2'b11
  } opcode_e;

endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (STAGES < 1) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
          stage_q[0] <= d_i;
          for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
      end

      assign q_o = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/tcs_frame.sv
module tcs_frame
  import trimser_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LOAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s_i,
  input  logic              csn_s_i,
  input  logic              sdi_s_i,
  input  logic              busy_i,
  input  logic              load_i,
  input  logic [LOAD_W-1:0] load_data_i,
  output logic              exec_o,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_o,
  output logic              oe_o
);

  localparam int              CNT_W    = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam int              PAD_W    = WORD_W - LOAD_W;

  logic              sclk_q, csn_q;
  frame_mode_e       mode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sr_q;
  logic              sdo_q;

  logic sclk_rise, sclk_fall, cs_fall, cs_rise;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign sclk_fall = ~sclk_s_i & sclk_q;
  assign cs_fall   = ~csn_s_i & csn_q;
  assign cs_rise   = csn_s_i & ~csn_q;

  // Previous synchronised levels for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      csn_q  <= csn_s_i;
    end
  end

  // Frame mode and saturating bit counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= FR_IDLE;
      cnt_q  <= '0;
    end else if (cs_fall) begin
      mode_q <= sclk_s_i ? FR_SHIFT : FR_STATUS;
      cnt_q  <= '0;
    end else if (cs_rise) begin
      mode_q <= FR_IDLE;
    end else if (mode_q == FR_SHIFT && sclk_rise && cnt_q != CNT_FULL) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Shift register: new bits enter at the top, the oldest sits at bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (mode_q == FR_SHIFT && sclk_rise) begin
      sr_q <= {sdi_s_i, sr_q[WORD_W-1:1]};
    end else if (load_i && mode_q != FR_SHIFT) begin
      sr_q <= {{PAD_W{1'b0}}, load_data_i};
    end
  end

  // Serial output: oldest bit in command frames, ready flag in status frames
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
    end else if (cs_fall) begin
      sdo_q <= sclk_s_i ? sr_q[0] : ~busy_i;
    end else if (mode_q == FR_STATUS) begin
      sdo_q <= ~busy_i;
    end else if (mode_q == FR_SHIFT && sclk_fall) begin
      sdo_q <= sr_q[0];
    end
  end

  assign exec_o = cs_rise && (mode_q == FR_SHIFT) && (cnt_q == CNT_FULL);
  assign word_o = sr_q;
  assign sdo_o  = sdo_q;
  assign oe_o   = (mode_q != FR_IDLE);

endmodule

// File: rtl/tcs_decode.sv
module tcs_decode
  import trimser_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 4,
  parameter int BANK_W = 2,
  parameter int NUM_CH = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 exec_i,
  input  logic [DATA_W+CHAN_W+2+BANK_W-1:0]    word_i,
  input  logic                                 busy_i,
  output logic                                 dac_ld_o,
  output logic                                 recall_o,
  output logic                                 recall_all_o,
  output logic                                 nv_wr_o,
  output logic                                 nv_rd_o,
  output logic [CHAN_W-1:0]                    chan_o,
  output logic [BANK_W-1:0]                    bank_o,
  output logic [DATA_W-1:0]                    data_o
);

  localparam int WR_POS   = DATA_W + CHAN_W;
  localparam int CL_POS   = WR_POS + 1;
  localparam int BANK_LSB = CL_POS + 1;

  localparam logic [CHAN_W-1:0] CODE_ALL  = '0;
  localparam logic [CHAN_W-1:0] CODE_OFF  = '1;
  localparam logic [CHAN_W-1:0] CODE_LAST = CHAN_W'(NUM_CH);

  logic [DATA_W-1:0] f_data;
  logic [CHAN_W-1:0] f_code;
  logic [BANK_W-1:0] f_bank;
  opcode_e           f_op;
  logic              chan_ok;
  logic              wen_q;

  assign f_data  = word_i[DATA_W-1:0];
  assign f_code  = word_i[DATA_W +: CHAN_W];
  assign f_bank  = word_i[BANK_LSB +: BANK_W];
  assign f_op    = opcode_e'({word_i[CL_POS], word_i[WR_POS]});
  assign chan_ok = (f_code != CODE_ALL) && (f_code <= CODE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_ld_o     <= 1'b0;
      recall_o     <= 1'b0;
      recall_all_o <= 1'b0;
      nv_wr_o      <= 1'b0;
      nv_rd_o      <= 1'b0;
      wen_q        <= 1'b0;
      chan_o       <= '0;
      bank_o       <= '0;
      data_o       <= '0;
    end else begin
      dac_ld_o     <= 1'b0;
      recall_o     <= 1'b0;
      recall_all_o <= 1'b0;
      nv_wr_o      <= 1'b0;
      nv_rd_o      <= 1'b0;
      if (exec_i) begin
        chan_o <= chan_ok ? f_code - 1'b1 : '0;
        bank_o <= f_bank;
        data_o <= f_data;
        unique case (f_op)
          OP_DAC: begin
            if (chan_ok) dac_ld_o <= 1'b1;
          end
          OP_RECALL: begin
            if (!busy_i) begin
              if (f_code == CODE_ALL) recall_all_o <= 1'b1;
              else if (chan_ok)       recall_o     <= 1'b1;
            end
          end
          OP_WRITE: begin
            if (!busy_i && wen_q && chan_ok) nv_wr_o <= 1'b1;
          end
          OP_READ: begin
            if (f_code == CODE_ALL)      wen_q   <= 1'b1;
            else if (f_code == CODE_OFF) wen_q   <= 1'b0;
            else if (chan_ok && !busy_i) nv_rd_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/trim_cmd_serial_if.sv
module trim_cmd_serial_if #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int CHAN_W      = 4,
  parameter int BANK_W      = 2,
  parameter int NUM_CH      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              nv_busy_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              dac_ld_o,
  output logic              recall_o,
  output logic              recall_all_o,
  output logic              nv_wr_o,
  output logic              nv_rd_o,
  output logic [CHAN_W-1:0] cmd_chan_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [DATA_W-1:0] cmd_data_o
);

  localparam int WORD_W = DATA_W + CHAN_W + 2 + BANK_W;

  logic [2:0]        pins_s;
  logic              exec;
  logic [WORD_W-1:0] word;

  // {chip select, serial clock, data}; chip select idles high
  tcs_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({csn_i, sclk_i, sdi_i}),
    .q_o  (pins_s)
  );

  tcs_frame #(
    .WORD_W(WORD_W),
    .LOAD_W(DATA_W)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_s_i   (pins_s[1]),
    .csn_s_i    (pins_s[2]),
    .sdi_s_i    (pins_s[0]),
    .busy_i     (nv_busy_i),
    .load_i     (rd_valid_i),
    .load_data_i(rd_data_i),
    .exec_o     (exec),
    .word_o     (word),
    .sdo_o      (sdo_o),
    .oe_o       (sdo_oe_o)
  );

  tcs_decode #(
    .DATA_W(DATA_W),
    .CHAN_W(CHAN_W),
    .BANK_W(BANK_W),
    .NUM_CH(NUM_CH)
  ) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_i      (exec),
    .word_i      (word),
    .busy_i      (nv_busy_i),
    .dac_ld_o    (dac_ld_o),
    .recall_o    (recall_o),
    .recall_all_o(recall_all_o),
    .nv_wr_o     (nv_wr_o),
    .nv_rd_o     (nv_rd_o),
    .chan_o      (cmd_chan_o),
    .bank_o      (cmd_bank_o),
    .data_o      (cmd_data_o)
  );

endmodule

// File: rtl/trim_cmd_serial_if_chk.sv
module trim_cmd_serial_if_chk #(
  parameter int CHAN_W = 4,
  parameter int NUM_CH = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn_i,
  input logic              nv_busy_i,
  input logic              sdo_oe_o,
  input logic              dac_ld_o,
  input logic              recall_o,
  input logic              recall_all_o,
  input logic              nv_wr_o,
  input logic              nv_rd_o,
  input logic [CHAN_W-1:0] cmd_chan_o
);

  logic [2:0] age_q;
  logic [4:0] strobes;

  assign strobes = {dac_ld_o, recall_o, recall_all_o, nv_wr_o, nv_rd_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end

  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  a_r12_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobes) |=> !(|strobes));

  a_r10_busy_blocks_storage: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd1 && (recall_o || recall_all_o || nv_wr_o || nv_rd_o)) |-> !$past(nv_busy_i));

  a_r5_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_ld_o || recall_o || nv_wr_o || nv_rd_o) |-> (cmd_chan_o < CHAN_W'(NUM_CH)));

  a_r11_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd4 && csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3)) |-> !sdo_oe_o);

endmodule

bind trim_cmd_serial_if trim_cmd_serial_if_chk #(
  .CHAN_W(CHAN_W),
  .NUM_CH(NUM_CH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csn_i       (csn_i),
  .nv_busy_i   (nv_busy_i),
  .sdo_oe_o    (sdo_oe_o),
  .dac_ld_o    (dac_ld_o),
  .recall_o    (recall_o),
  .recall_all_o(recall_all_o),
  .nv_wr_o     (nv_wr_o),
  .nv_rd_o     (nv_rd_o),
  .cmd_chan_o  (cmd_chan_o)
);

// File: tb/trim_cmd_serial_if_bench.sv
module trim_cmd_serial_if_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;   // system cycles per serial clock phase

  localparam logic [4:0] S_NONE = 5'b00000;
  localparam logic [4:0] S_DAC  = 5'b10000;
  localparam logic [4:0] S_REC  = 5'b01000;
  localparam logic [4:0] S_ALL  = 5'b00100;
  localparam logic [4:0] S_WR   = 5'b00010;
  localparam logic [4:0] S_RD   = 5'b00001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_i = 1'b1, csn_i = 1'b1, sdi_i = 1'b0;
  logic nv_busy_i = 1'b0, rd_valid_i = 1'b0;
  logic [7:0] rd_data_i = '0;
  logic sdo_o, sdo_oe_o, dac_ld_o, recall_o, recall_all_o, nv_wr_o, nv_rd_o;
  logic [3:0] cmd_chan_o;
  logic [1:0] cmd_bank_o;
  logic [7:0] cmd_data_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] captured;
  int          pulses, at_cycle;
  logic [4:0]  snap_vec;
  logic [3:0]  snap_chan;
  logic [1:0]  snap_bank;
  logic [7:0]  snap_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  trim_cmd_serial_if u_trim_cmd_serial_if (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .nv_busy_i(nv_busy_i),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .dac_ld_o(dac_ld_o), .recall_o(recall_o), .recall_all_o(recall_all_o),
    .nv_wr_o(nv_wr_o), .nv_rd_o(nv_rd_o), .cmd_chan_o(cmd_chan_o),
    .cmd_bank_o(cmd_bank_o), .cmd_data_o(cmd_data_o)
  );

  function automatic logic [15:0] mk(input logic [1:0] bank, input logic cl,
                                     input logic wr, input logic [3:0] code,
                                     input logic [7:0] data);
    return {bank, cl, wr, code, data};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Command frame: chip select falls with clock high, bits LSB first
  task automatic frame(input logic [31:0] bits, input int nbits);
    captured = '0;
    sclk_i = 1'b1;
    csn_i  = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk_i = 1'b0;
      sdi_i  = bits[i];
      tick(HALF);
      captured[i] = sdo_o;
      sclk_i = 1'b1;
      tick(HALF);
    end
    csn_i = 1'b1;
    pulses = 0; at_cycle = 0; snap_vec = '0;
    for (int c = 1; c <= 6; c++) begin
      tick(1);
      if (dac_ld_o | recall_o | recall_all_o | nv_wr_o | nv_rd_o) begin
        pulses++;
        if (pulses == 1) begin
          at_cycle  = c;
          snap_vec  = {dac_ld_o, recall_o, recall_all_o, nv_wr_o, nv_rd_o};
          snap_chan = cmd_chan_o;
          snap_bank = cmd_bank_o;
          snap_data = cmd_data_o;
        end
      end
    end
    tick(HALF);
  endtask

  task automatic expect_none(input string req);
    check({req, " no strobe"}, pulses, 0);
  endtask

  task automatic expect_pulse(input string req, input logic [4:0] vec,
                              input logic [3:0] chan, input logic [1:0] bank,
                              input logic [7:0] data, input bit chk_fields);
    check({req, " R12 pulse count"}, pulses, 1);
    check({req, " R12 pulse cycle"}, at_cycle, 3);
    check({req, " strobe kind"}, snap_vec, vec);
    if (chk_fields) begin
      check({req, " channel"}, snap_chan, chan);
      check({req, " bank"}, snap_bank, bank);
      check({req, " data"}, snap_data, data);
    end else begin
      check({req, " bank"}, snap_bank, bank);
    end
  endtask

  task automatic t_reset;
    tick(3);
    check("R1 strobes after reset",
          {dac_ld_o, recall_o, recall_all_o, nv_wr_o, nv_rd_o}, S_NONE);
    check("R1 oe after reset", sdo_oe_o, 0);
  endtask

  task automatic t_dac;
    frame(mk(2'd2, 0, 0, 4'd3, 8'h5A), 16);
    expect_pulse("R2 R5 dac ch3", S_DAC, 4'd2, 2'd2, 8'h5A, 1);
    frame(mk(2'd0, 0, 0, 4'd12, 8'hFF), 16);
    expect_pulse("R5 dac ch12", S_DAC, 4'd11, 2'd0, 8'hFF, 1);
    frame(mk(2'd1, 0, 0, 4'd13, 8'h11), 16);
    expect_none("R5 dac code13");
    frame(mk(2'd1, 0, 0, 4'd0, 8'h22), 16);
    expect_none("R5 dac code0");
    frame(mk(2'd1, 0, 0, 4'd15, 8'h23), 16);
    expect_none("R5 dac code15");
  endtask

  task automatic t_short;
    frame(mk(2'd0, 0, 0, 4'd1, 8'h44), 15);
    expect_none("R3 short frame");
  endtask

  task automatic t_write_enable;
    frame(mk(2'd1, 0, 1, 4'd5, 8'h33), 16);
    expect_none("R7 write while disabled");
    frame(mk(2'd0, 1, 1, 4'd0, 8'h00), 16);
    expect_none("R7 enable no strobe");
    frame(mk(2'd1, 0, 1, 4'd5, 8'h33), 16);
    expect_pulse("R7 write enabled", S_WR, 4'd4, 2'd1, 8'h33, 1);
    frame(mk(2'd0, 1, 1, 4'd15, 8'h00), 16);
    expect_none("R7 disable no strobe");
    frame(mk(2'd1, 0, 1, 4'd5, 8'h34), 16);
    expect_none("R7 write after disable");
  endtask

  task automatic t_recall;
    frame(mk(2'd3, 1, 0, 4'd7, 8'h00), 16);
    expect_pulse("R6 recall ch7", S_REC, 4'd6, 2'd3, 8'h00, 1);
    frame(mk(2'd1, 1, 0, 4'd0, 8'h00), 16);
    expect_pulse("R6 recall all", S_ALL, 4'd0, 2'd1, 8'h00, 0);
    frame(mk(2'd1, 1, 0, 4'd14, 8'h00), 16);
    expect_none("R6 recall code14");
  endtask

  task automatic t_read;
    frame(mk(2'd2, 1, 1, 4'd2, 8'h00), 16);
    expect_pulse("R8 read ch2", S_RD, 4'd1, 2'd2, 8'h00, 1);
    rd_data_i = 8'hA5; rd_valid_i = 1'b1;
    tick(1);
    rd_valid_i = 1'b0; rd_data_i = 8'h00;
    tick(2);
    frame(mk(2'd0, 0, 0, 4'd1, 8'h10), 16);
    check("R8 read byte out", captured[7:0], 8'hA5);
    check("R8 zeros after byte", captured[15:8], 8'h00);
    expect_pulse("R8 follow-up dac", S_DAC, 4'd0, 2'd0, 8'h10, 1);
  endtask

  task automatic t_cascade;
    logic [15:0] prev = mk(2'd0, 0, 0, 4'd1, 8'h10);
    logic [15:0] cmd  = mk(2'd1, 0, 0, 4'd9, 8'h6C);
    frame({8'h00, cmd, 8'hC3}, 24);
    check("R4 previous word out", captured[15:0], prev);
    check("R4 input delayed 16", captured[23:16], 8'hC3);
    expect_pulse("R4 last 16 bits", S_DAC, 4'd8, 2'd1, 8'h6C, 1);
  endtask

  task automatic t_busy;
    frame(mk(2'd0, 1, 1, 4'd0, 8'h00), 16);
    nv_busy_i = 1'b1;
    frame(mk(2'd0, 0, 1, 4'd1, 8'h77), 16);
    expect_none("R10 write busy");
    frame(mk(2'd0, 1, 1, 4'd1, 8'h00), 16);
    expect_none("R10 read busy");
    frame(mk(2'd0, 1, 0, 4'd1, 8'h00), 16);
    expect_none("R10 recall busy");
    frame(mk(2'd0, 1, 0, 4'd0, 8'h00), 16);
    expect_none("R10 recall all busy");
    frame(mk(2'd3, 0, 0, 4'd4, 8'h81), 16);
    expect_pulse("R10 dac while busy", S_DAC, 4'd3, 2'd3, 8'h81, 1);
    nv_busy_i = 1'b0;
    frame(mk(2'd0, 0, 1, 4'd1, 8'h77), 16);
    expect_pulse("R10 write after busy", S_WR, 4'd0, 2'd0, 8'h77, 1);
  endtask

  task automatic t_status;
    frame(mk(2'd0, 0, 0, 4'd2, 8'h99), 15);
    sclk_i = 1'b0;
    tick(HALF);
    check("R11 oe idle", sdo_oe_o, 0);
    nv_busy_i = 1'b1;
    csn_i = 1'b0;
    tick(HALF);
    check("R9 status oe", sdo_oe_o, 1);
    check("R9 busy flag", sdo_o, 0);
    nv_busy_i = 1'b0;
    tick(2);
    check("R9 ready flag", sdo_o, 1);
    csn_i = 1'b1;
    pulses = 0;
    for (int c = 1; c <= 6; c++) begin
      tick(1);
      if (dac_ld_o | recall_o | recall_all_o | nv_wr_o | nv_rd_o) pulses++;
    end
    check("R9 status close no strobe", pulses, 0);
    check("R11 oe after status", sdo_oe_o, 0);
    sclk_i = 1'b1;
    tick(HALF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    t_reset;
    t_dac;
    t_short;
    t_write_enable;
    t_recall;
    t_read;
    t_cascade;
    t_busy;
    t_status;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule